// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 32-bit virtual address into a physical address by two table lookups in a row. The top four bits pick an entry in a small segment table. A present segment entry names one of several page tables. The next twelve bits pick an entry in that page table. A present page entry supplies a physical base, and the low sixteen bits of the virtual address are added to that base. Either lookup can find an empty entry. In that case the block returns a fault and no address.

A requester offers one virtual address at a time with a valid/ready handshake. Two clock edges later it gets a single-cycle response that carries either the physical address or the fault flag. A separate configuration port loads segment entries and page entries, one entry per accepted write. A configuration write is refused while a translation is pending or being offered, so no table entry can change under a lookup that is in flight. The segment table is cleared by reset. Page entries power up empty, and they are removed by writing them back with the present bit low.

Top module: `segpage_xlat`

## Requirements
- R1: After reset, `req_ready` and `rsp_valid` read 1 and 0, `cfg_ready` reads 1 while `req_valid` is low, and every segment entry is absent, so any address requested before configuration faults.
- R2: The virtual address is split as segment = bits 31:28, page = bits 27:16 and offset = bits 15:0. Two addresses that differ only in the segment field can translate through different page tables.
- R3: When both entries are present, `rsp_addr` equals the page base plus the zero-extended offset, taken modulo 2^32, with `rsp_fault` low and no other flag.
- R4: If the selected segment entry is absent, the response has `rsp_fault`=1 and `rsp_addr`=0, whatever the page tables hold.
- R5: If the segment is present but the selected page entry in its table is absent, the response has `rsp_fault`=1 and `rsp_addr`=0.
- R6: A request accepted on edge N (req_valid and req_ready both high) drops `req_ready` for one cycle and raises `rsp_valid` for exactly one cycle after edge N+1. `req_ready` is high again in that same cycle.
- R7: `cfg_ready` is low while a translation is pending and while `req_valid` is high. An offered configuration write waits until it is accepted, and it does not affect the translation that was in flight.
- R8: `cfg_tgt`=0 writes segment entry `cfg_seg` as {present=`cfg_present`, table=`cfg_table`}. `cfg_tgt`=1 writes page entry `cfg_page` of table `cfg_table` as {present=`cfg_present`, base=`cfg_base`}. The write affects every request accepted after it, and several segments may name the same table.
- R9: Writing an entry with `cfg_present`=0 removes its mapping, and later requests that use it fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Segment or page entry absent |
| rsp_addr | output | 32 | Physical address, zero on fault |
| cfg_valid | input | 1 | Table write offered |
| cfg_ready | output | 1 | Table write can be taken |
| cfg_tgt | input | 1 | 0 = segment entry, 1 = page entry |
| cfg_seg | input | 4 | Segment entry index |
| cfg_table | input | log2(PT_NUM) | Page table number |
| cfg_page | input | 12 | Page entry index |
| cfg_present | input | 1 | Present bit for the written entry |
| cfg_base | input | 32 | Physical base for a page entry |

## Verification
The bench builds the block with PT_NUM = 4, which gives a two-bit table number. With four tables, two segments can point at different tables that hold the same page number, and two other segments can point at one shared table. This exposes index-concatenation and segment-to-table routing errors that a single-table build would hide. A base near the top of the address space reaches the modulo-2^32 wrap. A configuration write offered during a pending lookup exercises the hold rule against the scoreboard's expected old mapping.

// File: rtl/spx_pkg.sv
package spx_pkg;
  // Selects which table a configuration write targets.
  typedef enum logic {
    TGT_SEG  = 1'b0,
    TGT_PAGE = 1'b1
  } cfg_tgt_e;
endpackage

// File: rtl/spx_seg_table.sv
module spx_seg_table #(
  parameter int SEG_W = 4,
  parameter int PTI_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic             wr_present,
  input  logic [PTI_W-1:0] wr_table,
  input  logic [SEG_W-1:0] rd_seg,
  output logic             rd_present,
  output logic [PTI_W-1:0] rd_table
);
  localparam int N_SEG = 1 << SEG_W;

  logic [N_SEG-1:0]             present_q;
  logic [N_SEG-1:0][PTI_W-1:0]  table_q;

  // One small register set per segment; only the present bits need reset.
  for (genvar g = 0; g < N_SEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        present_q[g] <= 1'b0;
      end else if (wr_en && (wr_seg == SEG_W'(g))) begin
        present_q[g] <= wr_present;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_seg == SEG_W'(g))) begin
        table_q[g] <= wr_table;
      end
    end
  end

  assign rd_present = present_q[rd_seg];
  assign rd_table   = table_q[rd_seg];
endmodule

// File: rtl/spx_page_store.sv
module spx_page_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 33
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Power-up content: every page entry absent.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/spx_ctrl.sv
module spx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic cfg_valid,
  input  logic cfg_tgt,
  output logic req_ready,
  output logic cfg_ready,
  output logic accept,
  output logic seg_we,
  output logic page_we,
  output logic resolve
);
  import spx_pkg::*;

  logic busy_q;

  // A request has priority over a configuration write; both wait while a
  // lookup is pending.
  assign req_ready = ~busy_q;
  assign accept    = req_valid & ~busy_q;
  assign cfg_ready = ~busy_q & ~req_valid;

  assign seg_we  = cfg_valid & cfg_ready & (cfg_tgt_e'(cfg_tgt) == TGT_SEG);
  assign page_we = cfg_valid & cfg_ready & (cfg_tgt_e'(cfg_tgt) == TGT_PAGE);
  assign resolve = busy_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= accept;
  end
endmodule

// File: rtl/spx_resolve.sv
module spx_resolve #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             seg_ok,
  input  logic [PA_W:0]    pg_word,
  input  logic [OFF_W-1:0] off,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_addr
);
  logic            miss;
  logic [PA_W-1:0] sum;

  assign miss = ~seg_ok | ~pg_word[PA_W];
  assign sum  = pg_word[PA_W-1:0] + PA_W'(off);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_fault <= miss;
        rsp_addr  <= miss ? '0 : sum;
      end
    end
  end
endmodule

// File: rtl/segpage_xlat.sv
module segpage_xlat #(
  parameter int VA_W   = 32,
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 12,
  parameter int PA_W   = 32,
  parameter int PT_NUM = 2,
  localparam int PTI_W = (PT_NUM > 1) ? $clog2(PT_NUM) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_addr,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_tgt,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic [PTI_W-1:0]  cfg_table,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_present,
  input  logic [PA_W-1:0]   cfg_base
);
  localparam int OFF_W = VA_W - SEG_W - PAGE_W;
  localparam int PG_AW = PTI_W + PAGE_W;

  logic accept, seg_we, page_we, resolve;
  logic seg_present;
  logic [PTI_W-1:0] seg_table;
  logic [PA_W:0] pg_word;
  logic s1_seg_ok;
  logic [OFF_W-1:0] s1_off;

  spx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .cfg_valid (cfg_valid),
    .cfg_tgt   (cfg_tgt),
    .req_ready (req_ready),
    .cfg_ready (cfg_ready),
    .accept    (accept),
    .seg_we    (seg_we),
    .page_we   (page_we),
    .resolve   (resolve)
  );

  // Stage 1: segment lookup feeds the page-store read address.
  spx_seg_table #(.SEG_W(SEG_W), .PTI_W(PTI_W)) u_seg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (seg_we),
    .wr_seg     (cfg_seg),
    .wr_present (cfg_present),
    .wr_table   (cfg_table),
    .rd_seg     (req_va[VA_W-1 -: SEG_W]),
    .rd_present (seg_present),
    .rd_table   (seg_table)
  );

  spx_page_store #(.ADDR_W(PG_AW), .DATA_W(PA_W + 1)) u_pages (
    .clk     (clk),
    .wr_en   (page_we),
    .wr_addr ({cfg_table, cfg_page}),
    .wr_data ({cfg_present, cfg_base}),
    .rd_en   (accept),
    .rd_addr ({seg_table, req_va[OFF_W +: PAGE_W]}),
    .rd_data (pg_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_seg_ok <= 1'b0;
      s1_off    <= '0;
    end else if (accept) begin
      s1_seg_ok <= seg_present;
      s1_off    <= req_va[OFF_W-1:0];
    end
  end

  // Stage 2: present checks and base-plus-offset.
  spx_resolve #(.PA_W(PA_W), .OFF_W(OFF_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .fire      (resolve),
    .seg_ok    (s1_seg_ok),
    .pg_word   (pg_word),
    .off       (s1_off),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_addr  (rsp_addr)
  );
endmodule

// File: rtl/spx_xlat_chk.sv
module spx_xlat_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            cfg_valid,
  input logic            cfg_ready,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_addr
);
  // R6: an accepted request closes the request port for a cycle
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R6: response arrives after the second edge
  p_rsp_timing_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  // R6: response strobe lasts one cycle
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4 / R5: a fault carries a zero address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  // R7: no table write while a lookup is pending
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !cfg_ready);

  // R7: a write and a request are never taken on the same edge
  p_cfg_excl_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready) |-> !(req_valid && req_ready));
endmodule

bind segpage_xlat spx_xlat_chk #(.PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_addr  (rsp_addr)
);

// File: tb/tb_segpage_xlat.sv
module tb_segpage_xlat;
  localparam int PTW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic req_ready, rsp_valid, rsp_fault, cfg_ready;
  logic [31:0] rsp_addr;
  logic cfg_valid = 1'b0, cfg_tgt = 1'b0, cfg_present = 1'b0;
  logic [3:0] cfg_seg = '0;
  logic [PTW-1:0] cfg_table = '0;
  logic [11:0] cfg_page = '0;
  logic [31:0] cfg_base = '0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // Reference tables kept by the bench
  bit            m_seg_v [16];
  bit [PTW-1:0]  m_seg_t [16];
  bit [32:0]     m_page  [int];

  bit          q_f [$];
  logic [31:0] q_a [$];
  string       q_t [$];

  always #10 clk = ~clk;

  segpage_xlat #(.PT_NUM(4)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_tgt(cfg_tgt),
    .cfg_seg(cfg_seg), .cfg_table(cfg_table), .cfg_page(cfg_page),
    .cfg_present(cfg_present), .cfg_base(cfg_base)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_for(input logic [31:0] va, input string tag);
    int key;
    bit f;
    logic [31:0] a;
    key = m_seg_t[va[31:28]] * 4096 + int'(va[27:16]);
    f = 1'b1;
    a = '0;
    if (m_seg_v[va[31:28]] && m_page.exists(key) && m_page[key][32]) begin
      f = 1'b0;
      a = m_page[key][31:0] + {16'h0, va[15:0]};
    end
    q_f.push_back(f);
    q_a.push_back(a);
    q_t.push_back(tag);
  endtask

  task automatic send(input logic [31:0] va, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_va = va;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    expect_for(va, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_write(input bit tgt, input logic [3:0] seg, input logic [PTW-1:0] tb,
                           input logic [11:0] pg, input bit pres, input logic [31:0] base);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_tgt = tgt; cfg_seg = seg; cfg_table = tb;
    cfg_page = pg; cfg_present = pres; cfg_base = base;
    while (!cfg_ready) @(negedge clk);
    @(posedge clk);
    if (!tgt) begin
      m_seg_v[seg] = pres;
      m_seg_t[seg] = tb;
    end else begin
      m_page[int'(tb) * 4096 + int'(pg)] = {pres, base};
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic drain;
    for (int i = 0; i < 6; i++) @(negedge clk);
  endtask

  // Monitor: compares every response with the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_f.size() == 0) begin
        check(1'b0, "R6 unexpected response", 64'(rsp_addr), 64'h0);
      end else begin
        bit ef;
        logic [31:0] ea;
        string et;
        ef = q_f.pop_front();
        ea = q_a.pop_front();
        et = q_t.pop_front();
        check(rsp_fault == ef && rsp_addr == ea, et, {31'h0, rsp_fault, rsp_addr}, {31'h0, ef, ea});
      end
    end
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_seg_v[i] = 0; m_seg_t[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of the handshake outputs
    check(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'h1);
    check(cfg_ready == 1'b1, "R1 cfg_ready after reset", 64'(cfg_ready), 64'h1);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    // R1: no segment present before configuration
    send(32'h0000_0000, "R1 unconfigured segment faults");
    send(32'hAABC_0010, "R1 unconfigured segment faults (A)");
    drain();

    // R8: load tables
    cfg_write(1'b0, 4'hA, 2'd3, 12'h0, 1'b1, 32'h0);
    cfg_write(1'b1, 4'h0, 2'd3, 12'hABC, 1'b1, 32'h1234_0000);
    cfg_write(1'b0, 4'h1, 2'd1, 12'h0, 1'b1, 32'h0);
    cfg_write(1'b1, 4'h0, 2'd1, 12'hABC, 1'b1, 32'h8000_0000);
    cfg_write(1'b1, 4'h0, 2'd1, 12'h000, 1'b1, 32'hFFFF_F000);
    cfg_write(1'b0, 4'h2, 2'd3, 12'h0, 1'b1, 32'h0);
    cfg_write(1'b0, 4'h5, 2'd2, 12'h0, 1'b0, 32'h0);
    cfg_write(1'b1, 4'h0, 2'd2, 12'h000, 1'b1, 32'h0000_4000);

    send(32'hAABC_0010, "R2 R3 seg A page ABC");
    send(32'h1ABC_FFFF, "R2 same page other segment table 1");
    send(32'h1000_2345, "R3 wrap modulo 2^32");
    send(32'hAABD_0000, "R5 absent page in present segment");
    send(32'h5000_0001, "R4 absent segment over present page");
    send(32'hF123_4567, "R4 never-written segment");
    send(32'h2ABC_0004, "R8 shared table via segment 2");
    drain();

    // R6: cycle-exact handshake timing
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'hAABC_0100;
    @(posedge clk);
    expect_for(32'hAABC_0100, "R6 timed request result");
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R6 req_ready low while pending", 64'(req_ready), 64'h0);
    check(rsp_valid == 1'b0, "R6 no response after first edge", 64'(rsp_valid), 64'h0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R6 response after second edge", 64'(rsp_valid), 64'h1);
    check(req_ready == 1'b1, "R6 req_ready back", 64'(req_ready), 64'h1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R6 response lasts one cycle", 64'(rsp_valid), 64'h0);

    // R7: write offered during a pending lookup is held
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h1ABC_0002;
    @(posedge clk);
    expect_for(32'h1ABC_0002, "R7 in-flight sees old mapping");
    @(negedge clk);
    req_valid = 1'b0;
    cfg_valid = 1'b1; cfg_tgt = 1'b1; cfg_table = 2'd1; cfg_page = 12'hABC;
    cfg_present = 1'b1; cfg_base = 32'h0765_0000; cfg_seg = 4'h0;
    check(cfg_ready == 1'b0, "R7 cfg_ready low while pending", 64'(cfg_ready), 64'h0);
    while (!cfg_ready) @(negedge clk);
    @(posedge clk);
    m_page[1 * 4096 + 12'hABC] = {1'b1, 32'h0765_0000};
    @(negedge clk);
    cfg_valid = 1'b0;
    send(32'h1ABC_0002, "R7 held write applied afterwards");
    drain();

    // R9: removing mappings
    cfg_write(1'b1, 4'h0, 2'd3, 12'hABC, 1'b0, 32'h1234_0000);
    send(32'hAABC_0010, "R9 removed page faults");
    send(32'h2ABC_0004, "R9 removed page faults via shared table");
    cfg_write(1'b0, 4'h1, 2'd1, 12'h0, 1'b0, 32'h0);
    send(32'h1000_0000, "R9 removed segment faults");
    drain();

    check(q_f.size() == 0, "R6 all responses arrived", 64'(q_f.size()), 64'h0);
    finish_up();
  end
endmodule